// File: doc/BRIEF.md
# Windowed Command and Status Register Block

This block is the host-facing control point of a network controller. The host drives everything through one 16-bit command word: a 5-bit opcode in the upper bits and an 11-bit argument below it. Reading the status word at the same offset returns the selected register bank (window), a command-in-progress flag and eight interrupt source bits. The block decodes each command in the cycle it is written. It keeps the current window, the receive and transmit enables, the receive filter and three threshold values. It also latches interrupt events from the datapath, applies an interrupt mask and drives a single interrupt line.

Datapath logic outside the block consumes the enables, the reset pulses and the threshold values. It reports events as one-cycle pulses on `evt_i`. The command port is a plain write strobe with no back-pressure. A command is taken on every cycle in which `cmd_we` is high, including while the busy flag is set. The busy flag only tells the host that a reset is still settling.

Top module: `nic_cmd_status_regs`

## Requirements
- R1: The opcode sits in command bits 15..11 and the argument in bits 10..0. An opcode the block does not define (for example 0x06 or 0x1F) changes no output and no status bit.
- R2: After `rst_n` is released, the window is 0 and receive and transmit are disabled. The mask, the sources, the filter, the busy flag and `irq` are all 0. All three thresholds read 2047 with their enables low.
- R3: Opcode 0x01 makes argument bits 2..0 the current window. The new window appears on `window_sel` and on status bits 15..13 in the following cycle.
- R4: Opcodes 0x04 and 0x03 turn receive on and off. Opcodes 0x09 and 0x0A turn transmit on and off.
- R5: Opcode 0x05 (receive reset) or 0x0B (transmit reset) raises the matching reset pulse for exactly one cycle. It also sets status bit 12 for BUSY_CYCLES cycles, and it leaves both enables as they were.
- R6: Opcode 0x00 raises `glob_rst_pulse` for one cycle and sets status bit 12 for BUSY_CYCLES cycles. It also returns the window, the enables, the mask, the sources, the filter and the thresholds to their R2 values. This wins over any event in the same cycle.
- R7: Status bits 7..0 hold the sources, and the bit order is used by R8 and R9. Bit 0 is the latch, 1 adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 6 requested interrupt and 7 update statistics. A pulse on `evt_i` bit 1, 2, 3, 4, 5 or 7 sets that bit. Pulses on `evt_i` bits 0 and 6 have no effect. Opcode 0x0C sets bit 6.
- R8: Opcode 0x0D clears every status bit whose argument bit (7..0) is 1. An event that sets the same bit in the same cycle wins, so the bit stays 1.
- R9: Opcode 0x0E loads the mask from argument bits 7..0. The latch bit sets when a source bit whose mask bit is 1 changes from 0 to 1. `irq` is high while the latch is set and any source bit 7..1 with its mask bit set is 1.
- R10: Opcode 0x10 loads `rx_filter` from argument bits 3..0. Bit 0 accepts individual, bit 1 multicast, bit 2 broadcast and bit 3 all frames.
- R11: Opcodes 0x11, 0x12 and 0x13 load argument bits 10..0 into the RX-early, TX-available and TX-start thresholds. Each threshold's enable output is low exactly when its value is 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode and argument |
| evt_i | input | 8 | One-cycle interrupt event pulses, same bit order as status |
| status_data | output | 16 | Window, busy flag and interrupt sources |
| window_sel | output | 3 | Current register window |
| irq | output | 1 | Interrupt request |
| rx_en | output | 1 | Receive enable |
| tx_en | output | 1 | Transmit enable |
| glob_rst_pulse | output | 1 | One-cycle global reset pulse |
| rx_rst_pulse | output | 1 | One-cycle receive reset pulse |
| tx_rst_pulse | output | 1 | One-cycle transmit reset pulse |
| rx_filter | output | 4 | Receive address filter bits |
| rx_early_thresh | output | 11 | RX early threshold |
| tx_avail_thresh | output | 11 | TX available threshold |
| tx_start_thresh | output | 11 | TX start threshold |
| rx_early_thr_en | output | 1 | RX early threshold interrupt enabled |
| tx_avail_thr_en | output | 1 | TX available threshold interrupt enabled |
| tx_start_thr_en | output | 1 | TX start threshold interrupt enabled |

## Verification
Two things can land on the same source bit in one cycle: an acknowledge from the host and an event from the datapath. In that case the event must win, or an interrupt would be lost. The bench drives an acknowledge of RX complete on the same clock edge as an RX-complete pulse and expects status bit 4 to read 1 afterwards. It then repeats the acknowledge with no event and expects the bit to read 0. A second collision puts a global reset against a source event, and the bench expects every source bit to be cleared.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

  localparam int OP_W      = 5;
  localparam int LATCH_BIT = 0;
  localparam int REQ_BIT   = 6;
  localparam int THR_CNT   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RST = 5'h00,
    OP_WIN_SEL    = 5'h01,
    OP_RX_OFF     = 5'h03,
    OP_RX_ON      = 5'h04,
    OP_RX_RST     = 5'h05,
    OP_TX_ON      = 5'h09,
    OP_TX_OFF     = 5'h0A,
    OP_TX_RST     = 5'h0B,
    OP_SW_IRQ     = 5'h0C,
    OP_IRQ_ACK    = 5'h0D,
    OP_IRQ_MASK   = 5'h0E,
    OP_RX_FILT    = 5'h10,
    OP_THR_RXE    = 5'h11,
    OP_THR_TXA    = 5'h12,
    OP_THR_TXS    = 5'h13
  } csr_op_e;

  typedef struct packed {
    logic               glob_rst;
    logic               win_load;
    logic               rx_off;
    logic               rx_on;
    logic               rx_rst;
    logic               tx_on;
    logic               tx_off;
    logic               tx_rst;
    logic               sw_irq;
    logic               ack;
    logic               mask_load;
    logic               filt_load;
    logic [THR_CNT-1:0] thr_load;
  } csr_dec_t;

endpackage

// File: rtl/csr_cmd_decode.sv
module csr_cmd_decode
  import nic_csr_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic                  cmd_we,
  input  logic [CMD_W-1:0]      cmd_word,
  output csr_dec_t              dec,
  output logic [CMD_W-OP_W-1:0] arg
);
  localparam int ARG_W = CMD_W - OP_W;

  logic [OP_W-1:0] op;

  assign op  = cmd_word[CMD_W-1 -: OP_W];
  assign arg = cmd_word[ARG_W-1:0];

  always_comb begin
    dec = '0;
    if (cmd_we) begin
      case (op)
        OP_GLOBAL_RST: dec.glob_rst    = 1'b1;
        OP_WIN_SEL:    dec.win_load    = 1'b1;
        OP_RX_OFF:     dec.rx_off      = 1'b1;
        OP_RX_ON:      dec.rx_on       = 1'b1;
        OP_RX_RST:     dec.rx_rst      = 1'b1;
        OP_TX_ON:      dec.tx_on       = 1'b1;
        OP_TX_OFF:     dec.tx_off      = 1'b1;
        OP_TX_RST:     dec.tx_rst      = 1'b1;
        OP_SW_IRQ:     dec.sw_irq      = 1'b1;
        OP_IRQ_ACK:    dec.ack         = 1'b1;
        OP_IRQ_MASK:   dec.mask_load   = 1'b1;
        OP_RX_FILT:    dec.filt_load   = 1'b1;
        OP_THR_RXE:    dec.thr_load[0] = 1'b1;
        OP_THR_TXA:    dec.thr_load[1] = 1'b1;
        OP_THR_TXS:    dec.thr_load[2] = 1'b1;
        default:       dec             = '0;
      endcase
    end
  end
endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
  import nic_csr_pkg::*;
#(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             ack_en,
  input  logic [SRC_W-1:0] ack_bits,
  input  logic             sw_req,
  input  logic             mask_load,
  input  logic [SRC_W-1:0] mask_val,
  input  logic [SRC_W-1:0] evt,
  output logic [SRC_W-1:0] src,
  output logic             irq
);
  localparam logic [SRC_W-1:0] LATCH_ONE = SRC_W'(1) << LATCH_BIT;
  localparam logic [SRC_W-1:0] REQ_ONE   = SRC_W'(1) << REQ_BIT;
  localparam logic [SRC_W-1:0] HW_MASK   = ~(LATCH_ONE | REQ_ONE);

  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] set_v, clr_v, body_next, rising, src_next;
  logic             latch_next;

  always_comb begin
    set_v      = (evt & HW_MASK) | (sw_req ? REQ_ONE : '0);
    clr_v      = ack_en ? ack_bits : '0;
    body_next  = ((src & ~clr_v) | set_v) & ~LATCH_ONE;
    rising     = body_next & ~src & mask_q;
    latch_next = (src[LATCH_BIT] & ~clr_v[LATCH_BIT]) | (|rising);
    src_next   = body_next | (latch_next ? LATCH_ONE : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src    <= '0;
      mask_q <= '0;
    end else if (clear_all) begin
      src    <= '0;
      mask_q <= '0;
    end else begin
      src <= src_next;
      if (mask_load) mask_q <= mask_val;
    end
  end

  assign irq = src[LATCH_BIT] & (|(src & mask_q & ~LATCH_ONE));
endmodule

// File: rtl/csr_busy_timer.sv
module csr_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/nic_cmd_status_regs.sv
module nic_cmd_status_regs
  import nic_csr_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int WIN_W       = 3,
  parameter int SRC_W       = 8,
  parameter int THR_W       = 11,
  parameter int FILT_W      = 4,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [SRC_W-1:0]  evt_i,
  output logic [CMD_W-1:0]  status_data,
  output logic [WIN_W-1:0]  window_sel,
  output logic              irq,
  output logic              rx_en,
  output logic              tx_en,
  output logic              glob_rst_pulse,
  output logic              rx_rst_pulse,
  output logic              tx_rst_pulse,
  output logic [FILT_W-1:0] rx_filter,
  output logic [THR_W-1:0]  rx_early_thresh,
  output logic [THR_W-1:0]  tx_avail_thresh,
  output logic [THR_W-1:0]  tx_start_thresh,
  output logic              rx_early_thr_en,
  output logic              tx_avail_thr_en,
  output logic              tx_start_thr_en
);
  localparam int ARG_W = CMD_W - OP_W;
  localparam int PAD_W = CMD_W - WIN_W - 1 - SRC_W;
  localparam logic [THR_W-1:0] THR_OFF = {THR_W{1'b1}};

  csr_dec_t           dec;
  logic [ARG_W-1:0]   arg;
  logic [SRC_W-1:0]   src;
  logic               busy;
  logic [THR_W-1:0]   thr_q [THR_CNT];

  csr_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_we   (cmd_we),
    .cmd_word (cmd_data),
    .dec      (dec),
    .arg      (arg)
  );

  csr_irq_unit #(.SRC_W(SRC_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (dec.glob_rst),
    .ack_en    (dec.ack),
    .ack_bits  (arg[SRC_W-1:0]),
    .sw_req    (dec.sw_irq),
    .mask_load (dec.mask_load),
    .mask_val  (arg[SRC_W-1:0]),
    .evt       (evt_i),
    .src       (src),
    .irq       (irq)
  );

  csr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dec.glob_rst | dec.rx_rst | dec.tx_rst),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_sel     <= '0;
      rx_en          <= 1'b0;
      tx_en          <= 1'b0;
      rx_filter      <= '0;
      glob_rst_pulse <= 1'b0;
      rx_rst_pulse   <= 1'b0;
      tx_rst_pulse   <= 1'b0;
    end else begin
      glob_rst_pulse <= dec.glob_rst;
      rx_rst_pulse   <= dec.rx_rst;
      tx_rst_pulse   <= dec.tx_rst;
      if (dec.glob_rst) begin
        window_sel <= '0;
        rx_en      <= 1'b0;
        tx_en      <= 1'b0;
        rx_filter  <= '0;
      end else begin
        if (dec.win_load)  window_sel <= arg[WIN_W-1:0];
        if (dec.rx_off)    rx_en      <= 1'b0;
        else if (dec.rx_on) rx_en     <= 1'b1;
        if (dec.tx_off)    tx_en      <= 1'b0;
        else if (dec.tx_on) tx_en     <= 1'b1;
        if (dec.filt_load) rx_filter  <= arg[FILT_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < THR_CNT; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                thr_q[g] <= THR_OFF;
      else if (dec.glob_rst)     thr_q[g] <= THR_OFF;
      else if (dec.thr_load[g])  thr_q[g] <= arg[THR_W-1:0];
    end
  end

  assign rx_early_thresh = thr_q[0];
  assign tx_avail_thresh = thr_q[1];
  assign tx_start_thresh = thr_q[2];
  assign rx_early_thr_en = (thr_q[0] != THR_OFF);
  assign tx_avail_thr_en = (thr_q[1] != THR_OFF);
  assign tx_start_thr_en = (thr_q[2] != THR_OFF);

  assign status_data = {window_sel, busy, {PAD_W{1'b0}}, src};
endmodule

// File: rtl/nic_csr_checker.sv
module nic_csr_checker #(
  parameter int CMD_W = 16,
  parameter int WIN_W = 3,
  parameter int SRC_W = 8,
  parameter int THR_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [CMD_W-1:0] cmd_data,
  input logic [SRC_W-1:0] evt_i,
  input logic [CMD_W-1:0] status_data,
  input logic [WIN_W-1:0] window_sel,
  input logic             irq,
  input logic             rx_en,
  input logic             tx_en,
  input logic [THR_W-1:0] tx_start_thresh
);
  localparam int OPW = 5;
  localparam logic [SRC_W-1:0] EVT_OK = ~((SRC_W'(1) << 0) | (SRC_W'(1) << 6));

  logic [OPW-1:0] op;
  assign op = cmd_data[CMD_W-1 -: OPW];

  p_win_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == 5'h01) |=> (window_sel == $past(cmd_data[WIN_W-1:0]))
      && (status_data[CMD_W-1 -: WIN_W] == window_sel));

  p_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == 5'h03) |=> !rx_en);

  p_tx_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == 5'h09) |=> tx_en);

  p_glob_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == 5'h00) |=> (window_sel == '0) && (status_data[SRC_W-1:0] == '0)
      && status_data[CMD_W-WIN_W-1] && !rx_en && !tx_en);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == 5'h0D && ((evt_i & EVT_OK & cmd_data[SRC_W-1:0]) == '0))
      |=> ((status_data[SRC_W-1:1] & $past(cmd_data[SRC_W-1:1])) == '0));

  p_irq_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status_data[0]);

  p_thr_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == 5'h13) |=> (tx_start_thresh == $past(cmd_data[THR_W-1:0])));
endmodule

bind nic_cmd_status_regs nic_csr_checker #(
  .CMD_W(CMD_W), .WIN_W(WIN_W), .SRC_W(SRC_W), .THR_W(THR_W)
) u_csr_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_we          (cmd_we),
  .cmd_data        (cmd_data),
  .evt_i           (evt_i),
  .status_data     (status_data),
  .window_sel      (window_sel),
  .irq             (irq),
  .rx_en           (rx_en),
  .tx_en           (tx_en),
  .tx_start_thresh (tx_start_thresh)
);

// File: tb/test_nic_cmd_status_regs.sv
module test_nic_cmd_status_regs;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  evt_i = '0;
  logic [15:0] status_data;
  logic [2:0]  window_sel;
  logic        irq, rx_en, tx_en, glob_rst_pulse, rx_rst_pulse, tx_rst_pulse;
  logic [3:0]  rx_filter;
  logic [10:0] rx_early_thresh, tx_avail_thresh, tx_start_thresh;
  logic        rx_early_thr_en, tx_avail_thr_en, tx_start_thr_en;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_cmd_status_regs #(.BUSY_CYCLES(BUSY_N)) i_nic_cmd_status_regs (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data), .evt_i(evt_i),
    .status_data(status_data), .window_sel(window_sel), .irq(irq),
    .rx_en(rx_en), .tx_en(tx_en), .glob_rst_pulse(glob_rst_pulse),
    .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse), .rx_filter(rx_filter),
    .rx_early_thresh(rx_early_thresh), .tx_avail_thresh(tx_avail_thresh),
    .tx_start_thresh(tx_start_thresh), .rx_early_thr_en(rx_early_thr_en),
    .tx_avail_thr_en(tx_avail_thr_en), .tx_start_thr_en(tx_start_thr_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive one command for one cycle, with optional simultaneous events.
  task automatic cmd_ev(input logic [4:0] op, input logic [10:0] arg, input logic [7:0] ev);
    @(negedge clk);
    cmd_we   = 1'b1;
    cmd_data = {op, arg};
    evt_i    = ev;
    @(negedge clk);
    cmd_we   = 1'b0;
    cmd_data = '0;
    evt_i    = '0;
  endtask

  task automatic cmd(input logic [4:0] op, input logic [10:0] arg);
    cmd_ev(op, arg, 8'h00);
  endtask

  task automatic pulse_evt(input logic [7:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset_state;
    chk("R2 window", {29'd0, window_sel}, 32'd0);
    chk("R2 enables", {30'd0, rx_en, tx_en}, 32'd0);
    chk("R2 status", {16'd0, status_data}, 32'd0);
    chk("R2 irq", {31'd0, irq}, 32'd0);
    chk("R2 filter", {28'd0, rx_filter}, 32'd0);
    chk("R2 thresholds", {1'b0, rx_early_thresh, tx_avail_thresh, tx_start_thresh},
        {1'b0, 11'd2047, 11'd2047, 11'd2047});
    chk("R2 thr enables", {29'd0, rx_early_thr_en, tx_avail_thr_en, tx_start_thr_en}, 32'd0);
  endtask

  task automatic t_window;
    cmd(5'h01, 11'h7FD);
    chk("R3 window_sel", {29'd0, window_sel}, 32'd5);
    chk("R3 status window", {29'd0, status_data[15:13]}, 32'd5);
    cmd(5'h01, 11'h002);
    chk("R3 window 2", {29'd0, status_data[15:13]}, 32'd2);
  endtask

  task automatic t_enables;
    cmd(5'h04, 11'h000);
    chk("R4 rx on", {31'd0, rx_en}, 32'd1);
    chk("R4 tx still off", {31'd0, tx_en}, 32'd0);
    cmd(5'h09, 11'h000);
    chk("R4 tx on", {31'd0, tx_en}, 32'd1);
    cmd(5'h03, 11'h000);
    chk("R4 rx off", {31'd0, rx_en}, 32'd0);
    cmd(5'h0A, 11'h000);
    chk("R4 tx off", {31'd0, tx_en}, 32'd0);
  endtask

  task automatic t_sub_resets;
    cmd(5'h04, 11'h000);
    cmd(5'h05, 11'h000);
    chk("R5 rx pulse", {29'd0, rx_rst_pulse, tx_rst_pulse, glob_rst_pulse}, 32'b100);
    chk("R5 rx_en kept", {31'd0, rx_en}, 32'd1);
    for (int i = 0; i < BUSY_N; i++) begin
      chk("R5 busy held", {31'd0, status_data[12]}, 32'd1);
      @(negedge clk);
      if (i == 0) chk("R5 pulse one cycle", {31'd0, rx_rst_pulse}, 32'd0);
    end
    chk("R5 busy ends", {31'd0, status_data[12]}, 32'd0);
    cmd(5'h0B, 11'h000);
    chk("R5 tx pulse", {29'd0, rx_rst_pulse, tx_rst_pulse, glob_rst_pulse}, 32'b010);
    chk("R5 busy tx", {31'd0, status_data[12]}, 32'd1);
    cmd(5'h03, 11'h000);
    repeat (BUSY_N) @(negedge clk);
  endtask

  task automatic t_sources;
    pulse_evt(8'hFF);
    chk("R7 hw bits set, 0 and 6 ignored", {24'd0, status_data[7:0]}, 32'hBE);
    cmd(5'h0D, 11'h0FF);
    chk("R8 ack all", {24'd0, status_data[7:0]}, 32'h00);
    cmd(5'h0C, 11'h000);
    chk("R7 sw request bit6", {24'd0, status_data[7:0]}, 32'h40);
    cmd(5'h0D, 11'h040);
    chk("R8 ack bit6", {24'd0, status_data[7:0]}, 32'h00);
  endtask

  task automatic t_ack_collide;
    pulse_evt(8'h14);
    cmd_ev(5'h0D, 11'h014, 8'h10);
    chk("R8 event wins over ack", {24'd0, status_data[7:0]}, 32'h10);
    cmd(5'h0D, 11'h010);
    chk("R8 ack without event", {24'd0, status_data[7:0]}, 32'h00);
  endtask

  task automatic t_irq_mask;
    cmd(5'h0E, 11'h004);
    pulse_evt(8'h08);
    chk("R9 masked source no latch", {24'd0, status_data[7:0]}, 32'h08);
    chk("R9 no irq", {31'd0, irq}, 32'd0);
    pulse_evt(8'h04);
    chk("R9 latch set", {24'd0, status_data[7:0]}, 32'h0D);
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    cmd(5'h0D, 11'h001);
    chk("R9 irq drops with latch", {30'd0, irq, status_data[0]}, 32'd0);
    pulse_evt(8'h04);
    chk("R9 already set no relatch", {31'd0, irq}, 32'd0);
    cmd(5'h0D, 11'h004);
    pulse_evt(8'h04);
    chk("R9 relatch after ack", {31'd0, irq}, 32'd1);
    cmd(5'h0D, 11'h0FF);
  endtask

  task automatic t_filter;
    cmd(5'h10, 11'h7FA);
    chk("R10 filter", {28'd0, rx_filter}, 32'hA);
    cmd(5'h10, 11'h005);
    chk("R10 filter 2", {28'd0, rx_filter}, 32'h5);
  endtask

  task automatic t_thresholds;
    cmd(5'h11, 11'd100);
    cmd(5'h12, 11'd2046);
    cmd(5'h13, 11'd0);
    chk("R11 values", {1'b0, rx_early_thresh, tx_avail_thresh, tx_start_thresh},
        {1'b0, 11'd100, 11'd2046, 11'd0});
    chk("R11 enables", {29'd0, rx_early_thr_en, tx_avail_thr_en, tx_start_thr_en}, 32'b111);
    cmd(5'h12, 11'd2047);
    chk("R11 2047 disables", {29'd0, rx_early_thr_en, tx_avail_thr_en, tx_start_thr_en}, 32'b101);
  endtask

  task automatic t_unknown;
    cmd(5'h01, 11'h006);
    cmd(5'h04, 11'h000);
    pulse_evt(8'h02);
    cmd(5'h06, 11'h7FF);
    cmd(5'h1F, 11'h7FF);
    cmd(5'h17, 11'h000);
    chk("R1 window kept", {29'd0, window_sel}, 32'd6);
    chk("R1 rx kept", {31'd0, rx_en}, 32'd1);
    chk("R1 filter kept", {28'd0, rx_filter}, 32'h5);
    chk("R1 status kept", {16'd0, status_data}, {16'd0, 3'd6, 5'd0, 8'h02});
    chk("R1 no pulses", {29'd0, rx_rst_pulse, tx_rst_pulse, glob_rst_pulse}, 32'd0);
  endtask

  task automatic t_global;
    cmd(5'h0E, 11'h0FF);
    cmd(5'h09, 11'h000);
    cmd_ev(5'h00, 11'h000, 8'h20);
    chk("R6 pulse", {29'd0, rx_rst_pulse, tx_rst_pulse, glob_rst_pulse}, 32'b001);
    chk("R6 status cleared busy set", {16'd0, status_data}, 32'h1000);
    chk("R6 enables off", {30'd0, rx_en, tx_en}, 32'd0);
    chk("R6 filter", {28'd0, rx_filter}, 32'd0);
    chk("R6 thresholds", {1'b0, rx_early_thresh, tx_avail_thresh, tx_start_thresh},
        {1'b0, 11'd2047, 11'd2047, 11'd2047});
    repeat (BUSY_N) @(negedge clk);
    chk("R6 busy ends", {31'd0, status_data[12]}, 32'd0);
    pulse_evt(8'h80);
    chk("R6 mask cleared", {23'd0, irq, status_data[7:0]}, 32'h080);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_window();
    t_enables();
    t_sub_resets();
    t_sources();
    t_ack_collide();
    t_irq_mask();
    t_filter();
    t_thresholds();
    t_unknown();
    t_global();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule